// File: doc/BRIEF.md
# Byte-Lane Addressable Data Memory

This block is a 32-bit data memory that software addresses by byte. Storage is split into four 8-bit banks that all receive the same row index, which is the byte address with its two lowest bits dropped. The access size and the two low address bits decide which banks take part in an access. The whole word is available in one clock, with no faster secondary memory clock.

A store of a byte or halfword copies the narrow value into every lane, and only the enabled banks latch it. A load moves the selected byte or halfword down to bit 0. It then fills the upper bits with zeros or with copies of the sign bit. A halfword access on an odd address, or a word access that is not on a 4-byte boundary, is reported as misaligned and does not write anything. Lane order is little-endian, so bank 0 holds the byte at offset 0 within a row.

Top module: `byte_lane_mem`

## Requirements
- R1: While reset is held, `rdData` and `misaligned` read as zero.
- R2: Size codes 2'b10 and 2'b11 select a word access. A word store on an address with `addr[1:0]==0` writes all four lanes. A word load returns the byte at offset k of the row in bits 8k+7..8k.
- R3: Size code 2'b01 selects a halfword access. A halfword store writes only the lanes {0,1} when `addr[1]==0` and only the lanes {2,3} when `addr[1]==1`. The other two lanes of the row keep their contents.
- R4: Size code 2'b00 selects a byte access. A byte store writes only lane `addr[1:0]`, using bits 7..0 of `wrData`. The other lanes of the row are unchanged.
- R5: A byte load places the selected byte in `rdData[7:0]`. Bits 31..8 are zero when `signExt` is 0 and copies of bit 7 when `signExt` is 1.
- R6: A halfword load places the selected halfword in `rdData[15:0]`. The upper 16 bits are zero-filled or sign-filled from bit 15 according to `signExt`. A halfword store writes bits 15..0 of `wrData`, and the lower byte goes to the lower address.
- R7: `misaligned` is 1 in the cycle after a halfword access with `addr[0]==1` or a word access with `addr[1:0]!=0`. Such an access writes no lane, and the `rdData` it returns is zero.
- R8: Read data appears after the clock edge that samples the address. When a store and a load hit the same row in the same cycle, the load returns the contents from before the store.
- R9: Each row is indexed by `addr[ADDR_W-1:2]`, and a store to one row leaves every other row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the output registers |
| addr | input | ADDR_W | Byte address |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| wrEn | input | 1 | Store request |
| wrData | input | 32 | Store data, right-aligned |
| signExt | input | 1 | 1 sign-extends narrow loads, 0 zero-extends them |
| rdData | output | 32 | Aligned and extended load data, one cycle after the address |
| misaligned | output | 1 | Alignment fault of the access from the previous cycle |

## Verification
The bench builds the memory with ADDR_W=6, which gives 16 rows and 64 bytes. At that size every byte address can be swept with every size code, both extension modes, and both aligned and misaligned offsets. Every access is compared against a byte-array model held in the bench. After each narrow or faulting store, word reads of every row show that no neighbouring lane or row was disturbed.

// File: rtl/blm_pkg.sv
package blm_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } accSize_e;

  typedef struct packed {
    logic [LANES-1:0] laneWe;
    logic             misaligned;
    logic [OFF_W-1:0] offset;
    accSize_e         size;
    logic             signExt;
  } laneStrobe_t;

endpackage

// File: rtl/blm_lane_ctrl.sv
module blm_lane_ctrl
  import blm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wrEn,
  input  logic              signExt,
  output laneStrobe_t       strobe
);

  accSize_e         sizeE;
  logic             isWord;
  logic             badAlign;
  logic [LANES-1:0] accessMask;

  assign sizeE  = accSize_e'(size);
  assign isWord = (sizeE == SZ_WORD) || (sizeE == SZ_WORD_ALT);

  always_comb begin
    badAlign = 1'b0;
    if (sizeE == SZ_HALF && addr[0])
      badAlign = 1'b1;
    if (isWord && addr[OFF_W-1:0] != '0)
      badAlign = 1'b1;
  end

  always_comb begin
    case (sizeE)
      SZ_BYTE: accessMask = LANES'(1) << addr[OFF_W-1:0];
      SZ_HALF: accessMask = addr[1] ? 4'b1100 : 4'b0011;
      default: accessMask = '1;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.misaligned = badAlign;
    strobe.offset     = addr[OFF_W-1:0];
    strobe.size       = sizeE;
    strobe.signExt    = signExt;
    strobe.laneWe     = (wrEn && !badAlign) ? accessMask : '0;
  end

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sizeE == SZ_BYTE) |-> ($countones(strobe.laneWe) == 1)) // R4
    else $error("byte store enabled other than one lane");

  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sizeE == SZ_HALF && !addr[0]) |->
      (strobe.laneWe[0] == strobe.laneWe[1] && strobe.laneWe[2] == strobe.laneWe[3]
       && strobe.laneWe[0] != strobe.laneWe[2])) // R3
    else $error("halfword store did not enable exactly one lane pair");

  AST_MISALIGN_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.misaligned |-> (strobe.laneWe == '0)) // R7
    else $error("misaligned access enabled a lane");

endmodule

// File: rtl/blm_lane_datapath.sv
module blm_lane_datapath
  import blm_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wrData,
  input  laneStrobe_t       strobe,
  output logic [WORD_W-1:0] rdData,
  output logic              misaligned
);

  localparam int DEPTH = 1 << ROW_W;
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] wrSpread;
  logic [LANE_W-1:0] rdLane [LANES];
  logic [WORD_W-1:0] rdWord;

  logic [OFF_W-1:0]  offReg;
  accSize_e          sizeReg;
  logic              signReg;
  logic              misReg;

  always_comb begin
    case (strobe.size)
      SZ_BYTE: wrSpread = {LANES{wrData[LANE_W-1:0]}};
      SZ_HALF: wrSpread = {2{wrData[HALF_W-1:0]}};
      default: wrSpread = wrData;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.laneWe[g])
        laneMem[row] <= wrSpread[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN) rdLane[g] <= '0;
      else       rdLane[g] <= laneMem[row];
    end

    assign rdWord[g*LANE_W +: LANE_W] = rdLane[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg  <= '0;
      sizeReg <= SZ_WORD;
      signReg <= 1'b0;
      misReg  <= 1'b0;
    end else begin
      offReg  <= strobe.offset;
      sizeReg <= strobe.size;
      signReg <= strobe.signExt;
      misReg  <= strobe.misaligned;
    end
  end

  logic [LANE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;

  assign pickByte = rdWord[offReg*LANE_W +: LANE_W];
  assign pickHalf = offReg[1] ? rdWord[WORD_W-1:HALF_W] : rdWord[HALF_W-1:0];

  always_comb begin
    if (misReg) begin
      rdData = '0;
    end else begin
      case (sizeReg)
        SZ_BYTE: rdData = {{(WORD_W-LANE_W){signReg & pickByte[LANE_W-1]}}, pickByte};
        SZ_HALF: rdData = {{(WORD_W-HALF_W){signReg & pickHalf[HALF_W-1]}}, pickHalf};
        default: rdData = rdWord;
      endcase
    end
  end

  assign misaligned = misReg;

  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (rdData == '0)) // R7
    else $error("misaligned access returned data");

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (!misaligned && sizeReg == SZ_BYTE && !signReg) |-> (rdData[WORD_W-1:LANE_W] == '0)) // R5
    else $error("zero-extended byte has upper bits set");

  AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (!misaligned && sizeReg == SZ_BYTE && signReg) |->
      (rdData[WORD_W-1:LANE_W] == {(WORD_W-LANE_W){rdData[LANE_W-1]}})) // R5
    else $error("sign-extended byte has wrong fill");

  AST_HALF_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (!misaligned && sizeReg == SZ_HALF) |->
      (rdData[WORD_W-1:HALF_W] == {HALF_W{signReg & rdData[HALF_W-1]}})) // R6
    else $error("halfword extension wrong");

endmodule

// File: rtl/byte_lane_mem.sv
module byte_lane_mem
  import blm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              signExt,
  output logic [31:0]       rdData,
  output logic              misaligned
);

  localparam int ROW_W = ADDR_W - OFF_W;

  laneStrobe_t      strobe;
  logic [ROW_W-1:0] rowIdx;

  assign rowIdx = addr[ADDR_W-1:OFF_W];

  blm_lane_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .size    (size),
    .wrEn    (wrEn),
    .signExt (signExt),
    .strobe  (strobe)
  );

  blm_lane_datapath #(.ROW_W(ROW_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .row        (rowIdx),
    .wrData     (wrData),
    .strobe     (strobe),
    .rdData     (rdData),
    .misaligned (misaligned)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rstN) |-> (rdData == '0 && !misaligned)) // R1
    else $error("outputs not cleared by reset");

endmodule

// File: tb/byte_lane_mem_tb.sv
module byte_lane_mem_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 1 << ADDR_W;
  localparam int NROWS  = NBYTES / 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]        size = 2'b10;
  logic              wrEn = 1'b0;
  logic [31:0]       wrData = '0;
  logic              signExt = 1'b0;
  logic [31:0]       rdData;
  logic              misaligned;

  int testCount = 0;
  int failCount = 0;
  logic [7:0] model [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_mem #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .size(size), .wrEn(wrEn),
    .wrData(wrData), .signExt(signExt), .rdData(rdData), .misaligned(misaligned)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expMis(input int a, input logic [1:0] sz);
    if (sz == 2'b01) return a[0];
    if (sz[1]) return (a[1:0] != 2'b00);
    return 1'b0;
  endfunction

  function automatic logic [31:0] expLoad(input int a, input logic [1:0] sz, input logic sg);
    int b;
    logic [7:0] by;
    logic [15:0] h;
    if (expMis(a, sz)) return 32'h0;
    if (sz == 2'b00) begin
      by = model[a];
      return {{24{sg & by[7]}}, by};
    end
    if (sz == 2'b01) begin
      b = a & ~1;
      h = {model[b+1], model[b]};
      return {{16{sg & h[15]}}, h};
    end
    b = a & ~3;
    return {model[b+3], model[b+2], model[b+1], model[b]};
  endfunction

  // One access: drive at negedge, sample after the next rising edge.
  task automatic doAcc(input int a, input logic [1:0] sz, input logic we,
                       input logic [31:0] d, input logic sg, input string tag);
    logic [31:0] eData;
    logic        eMis;
    int b;
    eData = expLoad(a, sz, sg);
    eMis  = expMis(a, sz);
    @(negedge clk);
    addr = ADDR_W'(a); size = sz; wrEn = we; wrData = d; signExt = sg;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    check({tag, " data"}, rdData, eData);
    check({tag, " misaligned"}, {31'b0, misaligned}, {31'b0, eMis});
    if (we && !eMis) begin
      if (sz == 2'b00) model[a] = d[7:0];
      else if (sz == 2'b01) begin
        b = a & ~1;
        model[b] = d[7:0]; model[b+1] = d[15:8];
      end else begin
        b = a & ~3;
        for (int k = 0; k < 4; k++) model[b+k] = d[8*k +: 8];
      end
    end
  endtask

  task automatic scanRows(input string tag);
    for (int r = 0; r < NROWS; r++) doAcc(r*4, 2'b10, 1'b0, 32'h0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R1: outputs cleared while reset is held
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset data", rdData, 32'h0);
    check("R1 reset misaligned", {31'b0, misaligned}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 / R9: fill every row with a distinct word, both word codes
    for (int r = 0; r < NROWS; r++)
      doAcc(r*4, (r % 2) ? 2'b11 : 2'b10, 1'b1, 32'h80C0_0100 ^ (r * 32'h0103_0507), 1'b0, "R2 fill");
    scanRows("R2 R9 word readback");

    // R4: byte stores at every address; neighbours checked by word scan
    for (int a = 0; a < NBYTES; a++)
      doAcc(a, 2'b00, 1'b1, 32'hFFFF_FF00 | ((a * 37 + 5) & 32'hFF), 1'b0, "R4 byte store");
    scanRows("R4 R9 lane isolation");

    // R5: byte loads, both extension modes
    for (int a = 0; a < NBYTES; a++)
      for (int s = 0; s < 2; s++) doAcc(a, 2'b00, 1'b0, 32'h0, s[0], "R5 byte load");

    // R3 / R6: halfword stores at aligned halves, then loads
    for (int a = 0; a < NBYTES; a += 2)
      doAcc(a, 2'b01, 1'b1, 32'hABCD_0000 | ((a * 32'h0911 + 32'h7F3A) & 32'hFFFF), 1'b0, "R3 half store");
    scanRows("R3 R6 lane pair isolation");
    for (int a = 0; a < NBYTES; a += 2)
      for (int s = 0; s < 2; s++) doAcc(a, 2'b01, 1'b0, 32'h0, s[0], "R6 half load");

    // R7: misaligned stores of every kind are flagged and write nothing
    for (int a = 0; a < NBYTES; a++) begin
      if (a[0]) doAcc(a, 2'b01, 1'b1, 32'h0000_5A5A, 1'b1, "R7 half misaligned");
      if (a[1:0] != 2'b00) doAcc(a, a[2] ? 2'b11 : 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b0, "R7 word misaligned");
    end
    scanRows("R7 no write after fault");

    // R8: load in the same cycle as a store sees the old content
    for (int r = 0; r < NROWS; r++) doAcc(r*4, 2'b10, 1'b1, ~(r * 32'h1111_1111), 1'b0, "R8 read before write");
    scanRows("R8 new content");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule